// File: doc/BRIEF.md
# Burst Address Sequencing Controller

This block is the synchronous control front end of a burst-capable static memory. On every rising clock edge it samples two active-low burst-start strobes, an active-low advance input, three chip selects, the external word address and a decoded write flag. From these it classifies the cycle as a deselect, a burst start, a burst continue or a burst suspend. It then updates a registered base address, a burst counter, a valid flag and a read/write indication.

Both strobes can start a burst, but they follow different rules. The processor-side strobe wins when both are low. It is gated off entirely by the first chip select, and it always starts a read. The controller-side strobe starts a read or a write according to the write flag. After a start, the low address bits come from a counter that steps on advance and wraps after four words. A static order input picks one of two orderings. Linear ordering adds the count to the start offset. Interleaved ordering XORs the count with the start offset.

The outputs drive the storage array, which lies outside this block. They are the current word address, a flag saying the access is live, and a flag saying the access is a write.

Top module: `burst_seq_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the valid flag, the write flag, the base address and the burst counter. On the cycle after reset, word_addr is 0 and acc_valid is 0.
- R2: The chip counts as selected only when sel_a_n is 0, sel_b is 1 and sel_c_n is 0. If a strobe that is not blocked is sampled low while the chip is not selected, acc_valid is 0 on the next cycle.
- R3: While sel_a_n is 1, a low strb_proc_n has no effect. With strb_ctrl_n high, that cycle acts as a continue or a suspend according to adv_n.
- R4: A processor-strobe start with the chip selected gives acc_valid 1 and acc_write 0 on the next cycle, whatever the value of wr_req.
- R5: A controller-strobe start (strb_ctrl_n 0, strb_proc_n 1) with the chip selected gives acc_valid 1, and acc_write equals the wr_req sampled on that edge.
- R6: adv_n is ignored on a start edge. The first word_addr after any start equals the sampled addr_in exactly.
- R7: With both strobes high, adv_n 0 steps the counter. adv_n 1 leaves word_addr unchanged.
- R8: With order_ilv 0, the two low bits of word_addr equal (start + count) mod 4. After four words they return to the start value.
- R9: With order_ilv 1, the two low bits of word_addr equal start XOR count. For example, start 1 gives 1, 0, 3, 2.
- R10: On continue and suspend cycles the chip selects are not examined. A burst keeps stepping while every select is inactive.
- R11: A continue or suspend cycle while acc_valid is 0 leaves acc_valid 0 and does not move word_addr.
- R12: A start during a live burst takes effect at once. word_addr jumps to the new address on the next cycle.
- R13: On continue and suspend cycles of a live burst, acc_write follows the wr_req sampled on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| strb_proc_n | input | 1 | Processor-side burst start strobe, active low, gated by sel_a_n |
| strb_ctrl_n | input | 1 | Controller-side burst start strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| sel_a_n | input | 1 | First chip select, active low; also gates strb_proc_n |
| sel_b | input | 1 | Second chip select, active high |
| sel_c_n | input | 1 | Third chip select, active low |
| addr_in | input | AW | External word address |
| wr_req | input | 1 | Decoded write flag, 1 = write |
| order_ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| word_addr | output | AW | Current word address presented to the array |
| acc_valid | output | 1 | An access is live this cycle |
| acc_write | output | 1 | The live access is a write |

## Verification
The hardest situation to reach is a processor strobe held low while the first select is inactive, in the middle of a live burst. It has to act as an ordinary continue, not as a start or a deselect, and a design that decodes the strobe before the gate gets this wrong. The stimulus first builds a live interleaved burst. It then drives the blocked strobe together with a low advance and checks that the offset keeps stepping. The same burst is later carried through cycles with every select inactive, a restart in mid-burst, and a strobe that deselects. That last case shows that a following continue does not bring the access back.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  typedef enum logic [1:0] {
    CMD_HOLD  = 2'd0,
    CMD_DESEL = 2'd1,
    CMD_START = 2'd2,
    CMD_STEP  = 2'd3
  } burst_cmd_e;

endpackage

// File: rtl/burst_cmd_decode.sv
module burst_cmd_decode
  import burst_seq_pkg::*;
(
  input  logic       strb_proc_n,
  input  logic       strb_ctrl_n,
  input  logic       adv_n,
  input  logic       sel_a_n,
  input  logic       sel_b,
  input  logic       sel_c_n,
  output burst_cmd_e cmd,
  output logic       force_read
);

  logic chip_sel;
  logic proc_live;

  assign chip_sel  = !sel_a_n && sel_b && !sel_c_n;
  // first select gates the processor strobe off entirely
  assign proc_live = !strb_proc_n && !sel_a_n;

  always_comb begin
    cmd        = CMD_HOLD;
    force_read = 1'b0;
    if (proc_live) begin
      cmd        = chip_sel ? CMD_START : CMD_DESEL;
      force_read = 1'b1;
    end else if (!strb_ctrl_n) begin
      cmd = chip_sel ? CMD_START : CMD_DESEL;
    end else if (!adv_n) begin
      cmd = CMD_STEP;
    end else begin
      cmd = CMD_HOLD;
    end
  end

endmodule

// File: rtl/burst_counter.sv
module burst_counter
  import burst_seq_pkg::*;
#(
  parameter int BW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  burst_cmd_e    cmd,
  input  logic          force_read,
  input  logic          wr_req,
  output logic [BW-1:0] cnt,
  output logic          valid,
  output logic          wr
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      valid <= 1'b0;
      wr    <= 1'b0;
    end else begin
      unique case (cmd)
        CMD_START: begin
          cnt   <= '0;
          valid <= 1'b1;
          wr    <= wr_req && !force_read;
        end
        CMD_DESEL: begin
          valid <= 1'b0;
        end
        CMD_STEP: begin
          if (valid) begin
            cnt <= cnt + 1'b1;
            wr  <= wr_req;
          end
        end
        default: begin
          if (valid) wr <= wr_req;
        end
      endcase
    end
  end

endmodule

// File: rtl/burst_addr_map.sv
module burst_addr_map #(
  parameter int AW = 20,
  parameter int BW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] addr_in,
  input  logic [BW-1:0] cnt,
  input  logic          order_ilv,
  output logic [AW-1:0] word_addr
);

  logic [AW-1:0] base_q;
  logic [BW-1:0] start_off;
  logic [BW-1:0] cur_off;

  function automatic logic [BW-1:0] lin_offset(input logic [BW-1:0] s,
                                               input logic [BW-1:0] c);
    return s + c;
  endfunction

  function automatic logic [BW-1:0] ilv_offset(input logic [BW-1:0] s,
                                               input logic [BW-1:0] c);
    return s ^ c;
  endfunction

  always_ff @(posedge clk) begin
    if (rst)       base_q <= '0;
    else if (load) base_q <= addr_in;
  end

  assign start_off = base_q[BW-1:0];
  assign cur_off   = order_ilv ? ilv_offset(start_off, cnt)
                               : lin_offset(start_off, cnt);
  assign word_addr = {base_q[AW-1:BW], cur_off};

endmodule

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
#(
  parameter int AW = 20,
  parameter int BURST_BITS = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          strb_proc_n,
  input  logic          strb_ctrl_n,
  input  logic          adv_n,
  input  logic          sel_a_n,
  input  logic          sel_b,
  input  logic          sel_c_n,
  input  logic [AW-1:0] addr_in,
  input  logic          wr_req,
  input  logic          order_ilv,
  output logic [AW-1:0] word_addr,
  output logic          acc_valid,
  output logic          acc_write
);

  localparam int BW = BURST_BITS;

  burst_cmd_e    cmd;
  logic          force_read;
  logic [BW-1:0] burst_cnt;

  // named events for the checker
  logic start_evt;
  logic desel_evt;
  logic step_evt;
  logic hold_evt;

  assign start_evt = (cmd == CMD_START);
  assign desel_evt = (cmd == CMD_DESEL);
  assign step_evt  = (cmd == CMD_STEP);
  assign hold_evt  = (cmd == CMD_HOLD);

  burst_cmd_decode u_dec (
    .strb_proc_n (strb_proc_n),
    .strb_ctrl_n (strb_ctrl_n),
    .adv_n       (adv_n),
    .sel_a_n     (sel_a_n),
    .sel_b       (sel_b),
    .sel_c_n     (sel_c_n),
    .cmd         (cmd),
    .force_read  (force_read)
  );

  burst_counter #(.BW(BW)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .cmd        (cmd),
    .force_read (force_read),
    .wr_req     (wr_req),
    .cnt        (burst_cnt),
    .valid      (acc_valid),
    .wr         (acc_write)
  );

  burst_addr_map #(.AW(AW), .BW(BW)) u_map (
    .clk       (clk),
    .rst       (rst),
    .load      (start_evt),
    .addr_in   (addr_in),
    .cnt       (burst_cnt),
    .order_ilv (order_ilv),
    .word_addr (word_addr)
  );

endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk #(
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst,
  input logic          strb_proc_n,
  input logic          strb_ctrl_n,
  input logic          sel_a_n,
  input logic [AW-1:0] addr_in,
  input logic [AW-1:0] word_addr,
  input logic          acc_valid,
  input logic          acc_write,
  input logic          start_evt,
  input logic          desel_evt,
  input logic          step_evt,
  input logic          hold_evt
);

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (!acc_valid && word_addr == '0)); // R1

  AST_DESEL_DROPS: assert property (@(posedge clk) disable iff (rst)
    desel_evt |=> !acc_valid); // R2

  AST_BLOCKED_PROC: assert property (@(posedge clk) disable iff (rst)
    (sel_a_n && strb_ctrl_n) |-> !(start_evt || desel_evt)); // R3

  AST_PROC_READS: assert property (@(posedge clk) disable iff (rst)
    (start_evt && !strb_proc_n && !sel_a_n) |=> (acc_valid && !acc_write)); // R4

  AST_START_LOADS: assert property (@(posedge clk) disable iff (rst)
    start_evt |=> (word_addr == $past(addr_in))); // R12

  AST_SUSPEND_HOLDS: assert property (@(posedge clk) disable iff (rst)
    hold_evt |=> $stable(word_addr)); // R7

  AST_NO_REVIVE: assert property (@(posedge clk) disable iff (rst)
    (!acc_valid && (step_evt || hold_evt)) |=> !acc_valid); // R11

endmodule

bind burst_seq_ctrl burst_seq_chk #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .strb_proc_n (strb_proc_n),
  .strb_ctrl_n (strb_ctrl_n),
  .sel_a_n     (sel_a_n),
  .addr_in     (addr_in),
  .word_addr   (word_addr),
  .acc_valid   (acc_valid),
  .acc_write   (acc_write),
  .start_evt   (start_evt),
  .desel_evt   (desel_evt),
  .step_evt    (step_evt),
  .hold_evt    (hold_evt)
);

// File: tb/burst_seq_ctrl_tb.sv
module burst_seq_ctrl_tb;

  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          strb_proc_n = 1'b1, strb_ctrl_n = 1'b1, adv_n = 1'b1;
  logic          sel_a_n = 1'b0, sel_b = 1'b1, sel_c_n = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic          wr_req = 1'b0, order_ilv = 1'b0;
  logic [AW-1:0] word_addr;
  logic          acc_valid, acc_write;

  always #4 clk = ~clk;

  burst_seq_ctrl #(.AW(AW), .BURST_BITS(2)) u_dut (
    .clk(clk), .rst(rst), .strb_proc_n(strb_proc_n), .strb_ctrl_n(strb_ctrl_n),
    .adv_n(adv_n), .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .addr_in(addr_in), .wr_req(wr_req), .order_ilv(order_ilv),
    .word_addr(word_addr), .acc_valid(acc_valid), .acc_write(acc_write)
  );

  typedef struct {
    logic          v;
    logic          w;
    logic [AW-1:0] a;
    string         tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  // reference model state
  logic          m_v = 1'b0, m_w = 1'b0;
  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_off = 2'd0, m_cnt = 2'd0;

  task automatic push(input string tag);
    exp_t e;
    e.v   = m_v;
    e.w   = m_w;
    e.a   = {m_base[AW-1:2], m_off};
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst = 1'b1;
    strb_proc_n = 1'b1; strb_ctrl_n = 1'b1; adv_n = 1'b1;
    m_v = 1'b0; m_w = 1'b0; m_base = '0; m_off = 2'd0; m_cnt = 2'd0;
    push(tag);
  endtask

  task automatic drive(input logic p_n, input logic c_n, input logic a_n,
                       input logic s1n, input logic s2, input logic s3n,
                       input logic [AW-1:0] a, input logic w, input logic il,
                       input string tag);
    logic sel, pe;
    @(negedge clk);
    rst = 1'b0;
    strb_proc_n = p_n; strb_ctrl_n = c_n; adv_n = a_n;
    sel_a_n = s1n; sel_b = s2; sel_c_n = s3n;
    addr_in = a; wr_req = w; order_ilv = il;
    sel = !s1n && s2 && !s3n;
    pe  = !p_n && !s1n;
    if (pe || !c_n) begin
      if (sel) begin
        m_v = 1'b1; m_base = a; m_cnt = 2'd0; m_off = a[1:0];
        m_w = pe ? 1'b0 : w;
      end else begin
        m_v = 1'b0;
      end
    end else if (m_v) begin
      m_w = w;
      if (!a_n) begin
        m_cnt = m_cnt + 2'd1;
        m_off = il ? (m_base[1:0] ^ m_cnt) : (m_off + 2'd1);
      end
    end
    push(tag);
  endtask

  // monitor: compare one expected item after every edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        bit   bad;
        e   = exp_q.pop_front();
        bad = (acc_valid !== e.v) || (word_addr !== e.a) ||
              (e.v && (acc_write !== e.w));
        n_chk++;
        if (bad) begin
          n_bad++;
          $display("FAIL %s: valid=%0b write=%0b addr=%05h, expected valid=%0b write=%0b addr=%05h",
                   e.tag, acc_valid, acc_write, word_addr, e.v, e.w, e.a);
        end
      end
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    do_reset("R1 reset state");
    do_reset("R1 reset state");
    // processor start, write flag high and advance low ignored: R4 R6
    drive(0, 1, 0, 0, 1, 0, 20'h12341, 1, 0, "R4 R6 proc start read");
    // linear continue and wrap: R8
    drive(1, 1, 0, 0, 1, 0, '0, 0, 0, "R8 linear step 2");
    drive(1, 1, 0, 0, 1, 0, '0, 0, 0, "R8 linear step 3");
    drive(1, 1, 0, 0, 1, 0, '0, 0, 0, "R8 linear step 0");
    drive(1, 1, 0, 0, 1, 0, '0, 0, 0, "R8 linear wrap to start");
    // suspend holds, write flag follows: R7 R13
    drive(1, 1, 1, 0, 1, 0, '0, 1, 0, "R7 R13 suspend holds");
    drive(1, 1, 1, 0, 1, 0, '0, 0, 0, "R7 R13 suspend holds");
    // selects inactive on continue: R10
    drive(1, 1, 0, 1, 0, 1, '0, 0, 0, "R10 continue without select");
    drive(1, 1, 0, 1, 0, 1, '0, 1, 0, "R10 continue without select");
    // controller start write, interleaved: R5 R9
    drive(1, 0, 1, 0, 1, 0, 20'hABCD1, 1, 1, "R5 ctrl start write");
    drive(1, 1, 0, 0, 1, 0, '0, 1, 1, "R9 interleave 0");
    // blocked processor strobe acts as continue: R3
    drive(0, 1, 0, 1, 1, 0, 20'h00002, 1, 1, "R3 blocked proc strobe");
    drive(1, 1, 0, 0, 1, 0, '0, 1, 1, "R9 interleave 2");
    drive(1, 1, 0, 0, 1, 0, '0, 1, 1, "R9 interleave wrap");
    // controller start read: R5
    drive(1, 0, 0, 0, 1, 0, 20'h55552, 0, 1, "R5 ctrl start read");
    drive(1, 1, 0, 0, 1, 0, '0, 0, 1, "R9 interleave from 2");
    // restart mid burst: R12
    drive(0, 0, 0, 0, 1, 0, 20'h0F0F2, 1, 0, "R12 restart mid burst");
    drive(1, 1, 0, 0, 1, 0, '0, 0, 0, "R8 linear from 2");
    drive(1, 1, 0, 0, 1, 0, '0, 0, 0, "R8 linear from 2 wrap");
    // deselect by controller strobe with second select low: R2
    drive(1, 0, 0, 0, 0, 0, 20'h11111, 0, 0, "R2 deselect sel_b");
    // continue and suspend after deselect: R11
    drive(1, 1, 0, 0, 1, 0, '0, 1, 0, "R11 no revive step");
    drive(1, 1, 1, 0, 1, 0, '0, 1, 0, "R11 no revive hold");
    // restart, then processor strobe with third select high: R2
    drive(0, 1, 1, 0, 1, 0, 20'h22223, 0, 0, "R4 proc start");
    drive(0, 1, 0, 0, 1, 1, 20'h33330, 0, 0, "R2 deselect sel_c");
    // restart, then controller strobe with first select high: R2
    drive(1, 0, 1, 0, 1, 0, 20'h44440, 1, 0, "R5 ctrl start");
    drive(0, 0, 0, 1, 1, 0, 20'h66660, 0, 0, "R2 deselect sel_a");
    // reset in the middle of a burst: R1
    drive(1, 0, 1, 0, 1, 0, 20'h77773, 0, 1, "R5 ctrl start");
    drive(1, 1, 0, 0, 1, 0, '0, 0, 1, "R9 step before reset");
    do_reset("R1 reset mid burst");
    drive(1, 1, 0, 0, 1, 0, '0, 0, 0, "R11 idle after reset");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule